// File: doc/BRIEF.md
# Pulse Accumulator with Overflow and Input Flags

The block is an 8-bit event accumulator fed by an external pulse pin and exposed on a small synchronous register bus. In event mode it counts qualified transitions of the pin, with an input choosing rising or falling transitions. In gated mode it adds one to the count for every 64 system clocks that the pin spends at its active level, so the count measures how long the pin was active.

Two sticky flags report activity: one for the count wrapping from 0xFF to 0x00, one for an input transition (the qualified edge in event mode, the return to the inactive level in gated mode). Each flag has its own enable, and a single interrupt request output combines them. Software clears flags by writing ones to them; enables only gate the request, so software can also poll the flags with the enables at zero. The count register is not touched by reset and can be written at any time.

Top module: `pulse_acc`

## Requirements
- R1: Address 0 holds the 8-bit count; a bus write of any value to it reads back on the following cycle.
- R2: Reset leaves the count register unchanged; only the mask and flag registers are cleared.
- R3: After reset, the mask register (address 1) and flag register (address 2) read 0x00. The mask keeps bits 7, 6, 5, 4, 1 and 0; bits 3 and 2 of the mask, bits 7, 6, 3, 2, 1, 0 of the flag register and all of address 3 read 0.
- R4: In event mode (gated_i = 0), each transition of pulse_i in the direction chosen by edge_rise_i (1 = low-to-high, 0 = high-to-low) adds one to the count and sets the input flag at bit 4 of address 2; transitions the other way change neither.
- R5: In gated mode (gated_i = 1), the count advances by one on each 64th system clock while the synchronised input is at its active level (high when edge_rise_i = 1, low otherwise), stays still while inactive, and the input flag is set when the input goes back to its inactive level and not when it becomes active.
- R6: The overflow flag at bit 5 of address 2 is set when an increment takes the count from 0xFF to 0x00; a software write of 0x00 to the count does not set it.
- R7: Writing a 1 to bit 5 or bit 4 of address 2 clears that flag; writing 0 leaves it as it was.
- R8: When a clearing write and a set event for the same flag hit the same cycle, the flag ends up set.
- R9: When a count write and an increment hit the same cycle, the count takes the written value.
- R10: irq_o is 1 exactly when (bit 5 flag and bit 5 of the mask) or (bit 4 flag and bit 4 of the mask) are both 1; writing the mask never changes the flags.
- R11: A transition on pulse_i driven before clock edge n is reflected in the count after edge n+2 (two synchroniser stages plus the edge register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | External pulse pin, asynchronous |
| edge_rise_i | input | 1 | 1: rising edge / active-high, 0: falling edge / active-low |
| gated_i | input | 1 | 0: event counting, 1: gated time accumulation |
| addr_i | input | 2 | Register select: 0 count, 1 mask, 2 flags |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Event counting is driven with trains of pulses under both edge selections, so a design counting the wrong direction or both directions disagrees with the reference count by the number of opposite transitions. Gated mode gets one long active interval and one long inactive one, which separates a divided-clock accumulator from one counting edges or raw clocks, and shows whether the input flag is set on the release rather than the onset. Writes to the count and flag registers are placed on the exact cycle an increment or set event lands, which tells a write-priority count and set-priority flags from the reverse orderings, and a run across 0xFF distinguishes a true wrap from a written zero.

// File: rtl/pulse_acc_pkg.sv
package pulse_acc_pkg;
  localparam int DATA_W = 8;
  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_MASK = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
  localparam int OVF_BIT = 5;
  localparam int EDG_BIT = 4;
  localparam logic [DATA_W-1:0] MASK_KEEP = 8'hF3;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic active_high_i,
  output logic level_o,
  output logic act_edge_o,
  output logic inact_edge_o
);
  logic [STAGES:0] sh_q;
  logic cur_lvl, prev_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pulse_i};
  end

  assign cur_lvl      = active_high_i ? sh_q[STAGES-1] : ~sh_q[STAGES-1];
  assign prev_lvl     = active_high_i ? sh_q[STAGES]   : ~sh_q[STAGES];
  assign level_o      = cur_lvl;
  assign act_edge_o   = cur_lvl & ~prev_lvl;
  assign inact_edge_o = ~cur_lvl & prev_lvl;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_edge_o, inact_edge_o})); // R4
endmodule

// File: rtl/pa_count.sv
module pa_count #(
  parameter int DW  = 8,
  parameter int DIV = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gated_i,
  input  logic          level_i,
  input  logic          act_edge_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam int DIVW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DIV - 1);

  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   cnt_q;
  logic            tick, inc;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assign inc = gated_i ? (tick & level_i) : act_edge_i;

  // count has no reset by design
  always_ff @(posedge clk_i) begin
    if (wr_i)     cnt_q <= wdata_i;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc & ~wr_i & (&cnt_q);

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i))); // R9
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0)); // R6
  AST_GATED_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated_i && !wr_i && !tick) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/pa_flags.sv
module pa_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  // set takes priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);

  AST_SET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R8
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0)); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i | clr_i) == '0) |=> $stable(flag_q)); // R10
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pulse_acc_pkg::*;
#(
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              edge_rise_i,
  input  logic              gated_i,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int NFLAG = 2; // index 1 overflow, index 0 input

  reg_sel_e          sel;
  logic              level, act_edge, inact_edge, wrap;
  logic [DATA_W-1:0] cnt, mask_q;
  logic [NFLAG-1:0]  fl_set, fl_clr, fl_en, fl_q;

  assign sel = reg_sel_e'(addr_i);

  pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pulse_i,
    .active_high_i(edge_rise_i),
    .level_o(level), .act_edge_o(act_edge), .inact_edge_o(inact_edge)
  );

  pa_count #(.DW(DATA_W), .DIV(PRESCALE)) u_cnt (
    .clk_i, .rst_ni, .gated_i,
    .level_i(level), .act_edge_i(act_edge),
    .wr_i(we_i && sel == REG_CNT), .wdata_i,
    .cnt_o(cnt), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_q <= '0;
    else if (we_i && sel == REG_MASK) mask_q <= wdata_i & MASK_KEEP;
  end

  assign fl_set = {wrap, gated_i ? inact_edge : act_edge};
  assign fl_clr = {wdata_i[OVF_BIT], wdata_i[EDG_BIT]} & {NFLAG{we_i && sel == REG_FLAG}};
  assign fl_en  = {mask_q[OVF_BIT], mask_q[EDG_BIT]};

  pa_flags #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni,
    .set_i(fl_set), .clr_i(fl_clr), .en_i(fl_en),
    .flag_o(fl_q), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CNT:  rdata_o = cnt;
      REG_MASK: rdata_o = mask_q;
      REG_FLAG: begin
        rdata_o[OVF_BIT] = fl_q[1];
        rdata_o[EDG_BIT] = fl_q[0];
      end
      default:  rdata_o = '0;
    endcase
  end

  AST_IRQ_POLLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q[OVF_BIT] == 1'b0 && mask_q[EDG_BIT] == 1'b0) |-> !irq_o); // R10
  AST_MASK_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q[3:2] == 2'b00)); // R3
endmodule

// File: tb/pulse_acc_tb.sv
module pulse_acc_tb;
  logic       clk = 0, rst_ni = 0;
  logic       pulse_i = 0, edge_rise_i = 1, gated_i = 0, we_i = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_mask = 0, m_div = 0;
  bit m_known = 0, m_ovf = 0, m_edg = 0;
  bit hist[$] = '{0, 0, 0};

  always #2 clk = ~clk; // 250 MHz

  pulse_acc u_dut (
    .clk_i(clk), .rst_ni, .pulse_i, .edge_rise_i, .gated_i,
    .addr_i, .we_i, .wdata_i, .rdata_o, .irq_o
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{0, 0, 0}; m_ovf = 0; m_edg = 0; m_mask = 0; m_div = 0;
    end else begin
      bit lvl, prv, a_e, i_e, tk, inc, es, os, wr;
      int clr;
      lvl = edge_rise_i ? hist[1] : !hist[1];
      prv = edge_rise_i ? hist[2] : !hist[2];
      a_e = lvl && !prv;
      i_e = !lvl && prv;
      tk  = (m_div == 63);
      m_div = (m_div + 1) % 64;
      inc = gated_i ? (tk && lvl) : a_e;
      es  = gated_i ? i_e : a_e;
      wr  = we_i && addr_i == 0;
      os  = inc && !wr && m_cnt == 255;
      if (wr) begin m_cnt = wdata_i; m_known = 1; end
      else if (inc) m_cnt = (m_cnt + 1) % 256;
      clr = (we_i && addr_i == 2) ? int'(wdata_i) : 0;
      m_ovf = (m_ovf && !clr[5]) || os;
      m_edg = (m_edg && !clr[4]) || es;
      if (we_i && addr_i == 1) m_mask = wdata_i & 8'hF3;
      hist.push_front(pulse_i);
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int exp_rd;
      bit do_rd;
      do_rd = 1;
      case (addr_i)
        2'd0: begin exp_rd = m_cnt; do_rd = m_known; end
        2'd1: exp_rd = m_mask;
        2'd2: exp_rd = (int'(m_ovf) << 5) | (int'(m_edg) << 4);
        default: exp_rd = 0;
      endcase
      if (do_rd) chk("R1/R3/R4/R5 model read", rdata_o, exp_rd);
      chk("R10 model irq", irq_o, int'((m_ovf && m_mask[5]) || (m_edg && m_mask[4])));
    end
  end

  task automatic dp(); @(negedge clk); #1; endtask
  task automatic wait_n(int n); repeat (n) @(negedge clk); #1; endtask

  task automatic wr(int a, int d);
    dp(); addr_i = 2'(a); wdata_i = 8'(d); we_i = 1;
    dp(); we_i = 0;
  endtask

  task automatic rd(int a, output int v);
    dp(); addr_i = 2'(a); #1 v = rdata_o;
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      dp(); pulse_i = 1; wait_n(hi - 1);
      pulse_i = 0; wait_n(lo - 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int v;
    wait_n(3); rst_ni = 1; wait_n(2);
    rd(1, v); chk("R3 mask after reset", v, 0);
    rd(2, v); chk("R3 flags after reset", v, 0);
    rd(3, v); chk("R3 address 3 reads zero", v, 0);

    wr(0, 8'hFD); rd(0, v); chk("R1 count write readback", v, 8'hFD);
    wr(1, 8'hFF); rd(1, v); chk("R3 mask stored bits", v, 8'hF3);

    wr(1, 0);
    pulses(4, 4, 4); wait_n(4);
    rd(0, v); chk("R4 R6 rising edges wrap count", v, 8'h01);
    rd(2, v); chk("R4 R6 both flags set", v, 8'h30);
    chk("R10 polled: irq low with enables off", irq_o, 0);
    wr(1, 8'h20); rd(2, v); chk("R10 enable leaves flags", v, 8'h30);
    chk("R10 irq from overflow enable", irq_o, 1);
    wr(2, 8'h00); rd(2, v); chk("R7 write zero keeps flags", v, 8'h30);
    wr(2, 8'h20); rd(2, v); chk("R7 clear overflow", v, 8'h10);
    chk("R10 irq drops with flag", irq_o, 0);
    wr(2, 8'hFF); rd(2, v); chk("R7 R3 clear all", v, 0);

    wr(0, 8'hFF); wr(0, 8'h00); rd(2, v); chk("R6 written zero no overflow", v, 0);

    edge_rise_i = 0; wr(0, 8'h05); wr(2, 8'h30);
    dp(); pulse_i = 1; wait_n(5);
    rd(0, v); chk("R4 falling select ignores rise", v, 8'h05);
    rd(2, v); chk("R4 no flag on rise", v, 0);
    pulse_i = 0; wait_n(5);
    pulses(2, 4, 4); wait_n(4);
    rd(0, v); chk("R4 falling edges counted", v, 8'h08);
    edge_rise_i = 1; wait_n(4);

    wr(0, 8'h40); wr(2, 8'h30); addr_i = 0;
    dp(); pulse_i = 1;
    dp(); #1 chk("R11 after 1 edge", rdata_o, 8'h40);
    dp(); #1 chk("R11 after 2 edges", rdata_o, 8'h40);
    dp(); #1 chk("R11 after 3 edges", rdata_o, 8'h41);
    pulse_i = 0; wait_n(4);

    dp(); pulse_i = 1;
    dp(); dp(); addr_i = 0; wdata_i = 8'h77; we_i = 1;
    dp(); we_i = 0; #1 chk("R9 write beats increment", rdata_o, 8'h77);
    pulse_i = 0; wait_n(4); wr(2, 8'h30);

    dp(); pulse_i = 1;
    dp(); dp(); addr_i = 2; wdata_i = 8'h10; we_i = 1;
    dp(); we_i = 0; #1 chk("R8 set beats clear", rdata_o, 8'h10);
    pulse_i = 0; wait_n(4);

    wr(0, 8'h5A); wr(1, 8'h30);
    dp(); rst_ni = 0; wait_n(2); rst_ni = 1; wait_n(1);
    rd(0, v); chk("R2 count kept over reset", v, 8'h5A);
    rd(1, v); chk("R2 R3 mask cleared by reset", v, 0);

    gated_i = 1; wr(0, 0); wr(2, 8'h30);
    dp(); pulse_i = 1; wait_n(640);
    rd(0, v); chk("R5 gated count near 10", int'(v >= 9 && v <= 11), 1);
    rd(2, v); chk("R5 no flag at onset", v, 0);
    pulse_i = 0; wait_n(5);
    rd(2, v); chk("R5 flag at release", v, 8'h10);
    rd(0, v); wait_n(200); chk("R5 inactive holds count", int'(rdata_o), v);

    edge_rise_i = 0; wr(0, 8'hFE); wr(2, 8'h30); wr(1, 8'h30);
    wait_n(200);
    rd(2, v); chk("R5 R6 active-low gated overflow", v, 8'h20);
    chk("R10 irq with both enables", irq_o, 1);
    wait_n(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule